// File: doc/BRIEF.md
# Bidirectional strobed port controller

This block drives one 8-bit bidirectional pin bus that serves two peripheral directions. A host write puts a byte into an output latch and flags it with an active-low output-buffer-full signal. The pins stay released (output enable low) until the peripheral pulls its active-low acknowledge line. While acknowledge is low, the latched byte is driven onto the pins, and acknowledge empties the output buffer. For the input direction, the peripheral places data on the same pins and pulls an active-low strobe. The strobe captures the pins into a separate input latch and raises an input-buffer-full flag. A host read clears that flag.

Each direction has its own interrupt-enable flip-flop. A bit set/reset command writes these flip-flops: bit number 6 selects the output side and bit number 4 selects the input side. The two masked interrupt terms are ORed onto one request line. An 8-bit status word packs the five flags of this port above three bits passed in from a neighbouring port.

All inputs are sampled on the rising clock edge. Each state change is visible one cycle after the input that causes it. The pin enable and the interrupt request follow the live acknowledge and strobe levels without a clock delay.

Top module: `bidir_strobe_port`

## Requirements
- R1: After reset, `obf_n` = 1, `ibf` = 0, both interrupt enables = 0, `irq` = 0, and both latches hold 0.
- R2: `pad_oe` is 1 exactly while `ack_n` = 0. While `pad_oe` = 1, `pad_out` equals the byte from the most recent host write.
- R3: A cycle with `wr_en` = 1 stores `wr_data` into the output latch and makes `obf_n` = 0 from the next cycle on. If `ack_n` = 0 in the same cycle, the write still wins.
- R4: A cycle with `ack_n` = 0 and `wr_en` = 0 makes `obf_n` = 1 from the next cycle on.
- R5: Every cycle with `stb_n` = 0 stores `pad_in` into the input latch and sets `ibf` = 1 from the next cycle on. `rd_data` always shows the input latch.
- R6: A cycle with `rd_en` = 1 and `stb_n` = 1 clears `ibf` from the next cycle on. If `stb_n` = 0 in the same cycle, the strobe wins.
- R7: A cycle with `bsr_en` = 1 writes `bsr_val` into the output interrupt enable when `bsr_bit` = 6, and into the input interrupt enable when `bsr_bit` = 4. Any other `bsr_bit` value leaves both enables unchanged.
- R8: `irq` = (`obf_n` & `ack_n` & output enable) | (`ibf` & `stb_n` & input enable), evaluated on the current pin levels.
- R9: The bits of `status` are:
  - bit 7 = `obf_n`
  - bit 6 = output enable
  - bit 5 = `ibf`
  - bit 4 = input enable
  - bit 3 = `irq`
  - bits 2..0 = `aux_status`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe, one cycle |
| rd_data | output | 8 | Input latch contents |
| bsr_en | input | 1 | Bit set/reset command valid |
| bsr_bit | input | 3 | Bit number of the command |
| bsr_val | input | 1 | Value written by the command |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pad_in | input | 8 | Pin bus sampled value |
| pad_out | output | 8 | Pin bus drive value |
| pad_oe | output | 1 | Pin bus drive enable |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| irq | output | 1 | Shared interrupt request |
| aux_status | input | 3 | Neighbour port status bits |
| status | output | 8 | Packed status word |

## Verification
The bench sweeps every combination of write, read, acknowledge, strobe, and set/reset command across a thousand cycles. The sweep reaches the write-versus-acknowledge and read-versus-strobe collisions. A design that let acknowledge win the collision would lose a freshly written byte's full flag. A design that let a read win would drop a strobed byte. Commands that name bit numbers other than 4 and 6 are included, so that an enable written by a wrong bit would be caught. The interrupt is checked against the live strobe and acknowledge levels, so a request raised while either line is still low shows as a mismatch.

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port #(
  parameter int W          = 8,
  parameter int AUXW       = 3,
  parameter int OUT_IE_BIT = 6,
  parameter int IN_IE_BIT  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_en,
  output logic [W-1:0]    rd_data,
  input  logic            bsr_en,
  input  logic [2:0]      bsr_bit,
  input  logic            bsr_val,
  input  logic            stb_n,
  input  logic            ack_n,
  input  logic [W-1:0]    pad_in,
  output logic [W-1:0]    pad_out,
  output logic            pad_oe,
  output logic            obf_n,
  output logic            ibf,
  output logic            irq,
  input  logic [AUXW-1:0] aux_status,
  output logic [AUXW+4:0] status
);

  logic [W-1:0] out_q, in_q;
  logic         ie_out, ie_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      obf_n  <= 1'b1;
      in_q   <= '0;
      ibf    <= 1'b0;
      ie_out <= 1'b0;
      ie_in  <= 1'b0;
    end else begin
      if (wr_en) begin
        out_q <= wr_data;
        obf_n <= 1'b0;
      end else if (!ack_n) begin
        obf_n <= 1'b1;
      end
      if (!stb_n) begin
        in_q <= pad_in;
        ibf  <= 1'b1;
      end else if (rd_en) begin
        ibf  <= 1'b0;
      end
      if (bsr_en && bsr_bit == 3'(OUT_IE_BIT)) ie_out <= bsr_val;
      if (bsr_en && bsr_bit == 3'(IN_IE_BIT))  ie_in  <= bsr_val;
    end
  end

  assign pad_oe  = ~ack_n;
  assign pad_out = out_q;
  assign rd_data = in_q;
  assign irq     = (obf_n & ack_n & ie_out) | (ibf & stb_n & ie_in);
  assign status  = {obf_n, ie_out, ibf, ie_in, irq, aux_status};

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !obf_n); // R3
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !wr_en) |=> obf_n); // R4
  AST_STB_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |=> (ibf && rd_data == $past(pad_in))); // R5
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stb_n) |=> !ibf); // R6
  AST_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bsr_en |=> ($stable(status[AUXW+3]) && $stable(status[AUXW+1]))); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((obf_n && ack_n) || (ibf && stb_n))); // R8
  AST_DRIVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(wr_en)) |-> pad_out == $past(wr_data)); // R2

endmodule

// File: tb/test_bidir_strobe_port.sv
module test_bidir_strobe_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, bsr_en = 0, bsr_val = 0;
  logic [7:0] wr_data = 0, pad_in = 0;
  logic [2:0] bsr_bit = 0, aux_status = 0;
  logic       stb_n = 1, ack_n = 1;
  logic [7:0] rd_data, pad_out, status;
  logic       pad_oe, obf_n, ibf, irq;

  int checks = 0, errors = 0;

  logic [7:0] m_out = 0, m_in = 0;
  logic       m_obf_n = 1, m_ibf = 0, m_ieo = 0, m_iei = 0, m_irq;

  always #2.5 clk = ~clk;

  bidir_strobe_port i_bidir_strobe_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bsr_en(bsr_en), .bsr_bit(bsr_bit),
    .bsr_val(bsr_val), .stb_n(stb_n), .ack_n(ack_n), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .obf_n(obf_n), .ibf(ibf),
    .irq(irq), .aux_status(aux_status), .status(status));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    m_irq = (m_obf_n & ack_n & m_ieo) | (m_ibf & stb_n & m_iei);
    chk("R2 pad_oe", {7'd0, pad_oe}, {7'd0, ~ack_n});
    if (!ack_n) chk("R2 pad_out", pad_out, m_out);
    chk("R3/R4 obf_n", {7'd0, obf_n}, {7'd0, m_obf_n});
    chk("R5/R6 ibf", {7'd0, ibf}, {7'd0, m_ibf});
    chk("R5 rd_data", rd_data, m_in);
    chk("R8 irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R7/R9 status", status, {m_obf_n, m_ieo, m_ibf, m_iei, m_irq, aux_status});
  endtask

  task automatic model_edge();
    if (wr_en) begin m_out = wr_data; m_obf_n = 0; end
    else if (!ack_n) m_obf_n = 1;
    if (!stb_n) begin m_in = pad_in; m_ibf = 1; end
    else if (rd_en) m_ibf = 0;
    if (bsr_en && bsr_bit == 3'd6) m_ieo = bsr_val;
    if (bsr_en && bsr_bit == 3'd4) m_iei = bsr_val;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 obf_n", {7'd0, obf_n}, 8'd1);
    chk("R1 ibf", {7'd0, ibf}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 rd_data", rd_data, 8'd0);
    chk("R1 status", status, 8'h80);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      wr_en      = i[0];
      rd_en      = i[1];
      ack_n      = i[2];
      stb_n      = i[3];
      bsr_en     = i[4];
      case (i[6:5])
        2'd0: bsr_bit = 3'd4;
        2'd1: bsr_bit = 3'd6;
        2'd2: bsr_bit = 3'd5;
        default: bsr_bit = 3'(i[9:8] == 2'd0 ? 3 : 7);
      endcase
      bsr_val    = i[7] ^ i[9];
      wr_data    = 8'(i * 37 + 5);
      pad_in     = 8'(i * 91 + 17);
      aux_status = 3'(i[9:7] ^ i[2:0]);
      #1;
      check_all();
      @(posedge clk);
      model_edge();
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; bsr_en = 0; stb_n = 1; ack_n = 1;
    #1;
    check_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule